// File: doc/BRIEF.md
# One-Time-Programmable Fuse Command Sequencer

This block is a register-mapped controller placed between a 32-bit single-cycle register bus and a behavioural array of 32-bit fuse words. Software first asks for array power and waits until the power-good status bit rises. It then issues one command at a time through the control register. A read copies a fuse word into a shadow word that the bus can reach. A program burns a prepared write-data value into a word. A lock command burns the protection bit or bits for a chosen word into a small permanent-lock area. While a command runs, a busy flag stays high and further commands are dropped.

Results are reported in three places. A program-fail status bit covers refused programming. One bitmap bank per 32 words holds a per-word error flag. Another bitmap bank holds a per-word disturbed flag, which is set when a word read back after burning does not match the value that was intended. Fuse timing is modelled with fixed cycle counts. The array model can carry one defective word whose masked bits never burn, so that a read-back mismatch can occur.

Top module: `otp_fuse_seq`

## Requirements
- R1: `pwr_ok` (status bit 5) follows the power request (configuration bit 0) exactly PWR_DLY clock cycles after the request changes, and it never changes unless the request differs from it.
- R2: A read command (control bit 8 clear, word index in control bits 7:0) copies fuse word i into the shadow word at byte offset 0x200 + 4*i when the command finishes.
- R3: A program command (control bit 8 set, bit 9 clear) ORs the write-data register (offset 0x008) into fuse word i. Bits already at 1 stay at 1, so repeated programs accumulate.
- R4: Status bit 3 (busy) is high from the cycle after a command is accepted until the command finishes. A control write made while busy is ignored.
- R5: When bit 4 of the global lock register (offset 0x010, write-1-to-set) is set, program and lock commands burn nothing. They set status bit 4 (program fail) and the word's error flag. The next accepted command clears program fail.
- R6: A command written while `pwr_ok` is low is ignored (busy stays low, no fuse changes) and sets the error flag of the addressed word.
- R7: The error flag of word i sits in the register at 0x034 + 4*(i>>5), bit i%32. The disturbed flag sits in the register at 0x01C + 4*(i>>5), bit i%32. A successful read clears both flags for that word.
- R8: After a program, a read-back that differs from the intended OR value sets the word's disturbed flag and clears its error flag.
- R9: A lock command (control bits 9 and 8 set) for a word i below UPPER_BASE ORs 3 << (2*(i%8)) into lock-area word i>>3.
- R10: A lock command for a word i at or above UPPER_BASE ORs 1 << (i%16) into lock-area word (i>>4)+2. Lock-area word k reads at offset 0x0C0 + 4*k.
- R11: A bus write to a shadow word changes only that shadow word. A later read command restores the fuse contents.
- R12: After reset, every register, bitmap, shadow word, lock-area word and fuse word reads 0.
- R13: A command whose index field is N_WORDS or greater is ignored: busy stays low and no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
The bench builds the block with 96 words split at UPPER_BASE 32, a power delay of 4 cycles, read and program lengths of 3 and 6 cycles, and word 70 made defective on bit 8. The short delays let the bench check power-good timing to the exact cycle and keep a command in flight long enough to test that a second command is dropped. Three banks exercise the bank and bit mapping above bank 0. The defective word makes a disturbed flag reachable. The 32-word lower region and the 64-word upper region give both lock encodings at least two lock-area words each.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} fsm_t;
  typedef enum logic [1:0] {OP_READ, OP_PROG, OP_LOCK} op_t;

  localparam logic [11:0] A_CFG    = 12'h000;
  localparam logic [11:0] A_CTRL   = 12'h004;
  localparam logic [11:0] A_WDATA  = 12'h008;
  localparam logic [11:0] A_STATUS = 12'h00C;
  localparam logic [11:0] A_GLOCK  = 12'h010;
  localparam logic [11:0] A_DIST   = 12'h01C;
  localparam logic [11:0] A_ERR    = 12'h034;
  localparam logic [11:0] A_LKWIN  = 12'h0C0;
  localparam logic [11:0] A_SHADOW = 12'h200;

  localparam int PLOCK_BIT = 4;
  localparam int BUSY_BIT  = 3;
  localparam int FAIL_BIT  = 4;
  localparam int PWR_BIT   = 5;

  // lock-area word that guards fuse word idx
  function automatic int unsigned lk_word(int unsigned idx, int unsigned upper);
    return (idx < upper) ? (idx >> 3) : ((idx >> 4) + 2);
  endfunction

  // bit position of the guard inside that lock-area word
  function automatic int unsigned lk_shift(int unsigned idx, int unsigned upper);
    return (idx < upper) ? ((idx & 7) << 1) : (idx & 15);
  endfunction

  function automatic logic [31:0] lk_data(int unsigned idx, int unsigned upper);
    return (idx < upper) ? (32'd3 << lk_shift(idx, upper))
                         : (32'd1 << lk_shift(idx, upper));
  endfunction

endpackage

// File: rtl/otp_fuse_pwr.sv
module otp_fuse_pwr #(
  parameter int PWR_DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_req,
  output logic pwr_ok
);
  localparam int CW = $clog2(PWR_DLY + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pwr_ok <= 1'b0;
    end else if (pwr_req == pwr_ok) begin
      cnt <= '0;
    end else if (cnt == CW'(PWR_DLY - 1)) begin
      cnt    <= '0;
      pwr_ok <= pwr_req;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_pwr_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok != $past(pwr_ok)) |-> ($past(pwr_req) == pwr_ok));

endmodule

// File: rtl/otp_fuse_fsm.sv
module otp_fuse_fsm import otp_fuse_pkg::*; #(
  parameter int IDXW    = 7,
  parameter int RD_CYC  = 3,
  parameter int PRG_CYC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_go,
  input  op_t             cmd_op,
  input  logic [IDXW-1:0] cmd_idx,
  input  logic            cmd_refuse,
  output logic            busy,
  output logic            burn,
  output logic            fin,
  output op_t             cur_op,
  output logic [IDXW-1:0] cur_idx,
  output logic            cur_refused
);
  localparam int MAXC = (RD_CYC > PRG_CYC) ? RD_CYC : PRG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  fsm_t          state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      cur_op      <= OP_READ;
      cur_idx     <= '0;
      cur_refused <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_go) begin
          cur_op      <= cmd_op;
          cur_idx     <= cmd_idx;
          cur_refused <= cmd_refuse;
          cnt         <= (cmd_op == OP_READ) ? CW'(RD_CYC - 1) : CW'(PRG_CYC - 1);
          state       <= cmd_refuse ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          if (cnt == '0) state <= ST_FIN;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign fin  = (state == ST_FIN);
  assign burn = (state == ST_RUN) && (cnt == '0) && (cur_op != OP_READ);

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |=> busy);
  p_fin_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);
  p_go_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> !busy);

endmodule

// File: rtl/otp_fuse_model.sv
module otp_fuse_model #(
  parameter int          N_WORDS    = 96,
  parameter int          LOCK_WORDS = 8,
  parameter int          IDXW       = 7,
  parameter int          BAD_WORD   = 0,
  parameter logic [31:0] BAD_MASK   = 32'h0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     burn_en,
  input  logic                     burn_lock,
  input  logic [IDXW-1:0]          burn_addr,
  input  logic [31:0]              burn_data,
  input  logic [IDXW-1:0]          rd_idx,
  output logic [31:0]              rd_word,
  output logic [LOCK_WORDS*32-1:0] lock_flat
);
  logic [31:0] mem  [N_WORDS];
  logic [31:0] lkar [LOCK_WORDS];
  logic [31:0] eff_data;

  assign eff_data = (!burn_lock && burn_addr == IDXW'(BAD_WORD)) ? (burn_data & ~BAD_MASK)
                                                                 : burn_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WORDS; i++) mem[i] <= '0;
      for (int k = 0; k < LOCK_WORDS; k++) lkar[k] <= '0;
    end else if (burn_en) begin
      if (burn_lock) lkar[burn_addr] <= lkar[burn_addr] | eff_data;
      else           mem[burn_addr]  <= mem[burn_addr] | eff_data;
    end
  end

  assign rd_word = mem[rd_idx];

  for (genvar k = 0; k < LOCK_WORDS; k++) begin : g_lk
    assign lock_flat[k*32 +: 32] = lkar[k];
  end

  p_bits_stick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (burn_en && !burn_lock) |=> ((mem[$past(burn_addr)] & $past(eff_data)) == $past(eff_data)));

endmodule

// File: rtl/otp_fuse_seq.sv
module otp_fuse_seq import otp_fuse_pkg::*; #(
  parameter int          N_WORDS    = 96,
  parameter int          UPPER_BASE = 32,
  parameter int          PWR_DLY    = 16,
  parameter int          RD_CYC     = 8,
  parameter int          PRG_CYC    = 40,
  parameter int          BAD_WORD   = 0,
  parameter logic [31:0] BAD_MASK   = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int IDXW       = $clog2(N_WORDS);
  localparam int NBANK      = (N_WORDS + 31) / 32;
  localparam int LOCK_WORDS = int'(lk_word(N_WORDS - 1, UPPER_BASE)) + 1;
  localparam int LAW        = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;
  localparam logic [7:0] N_IDX = 8'(N_WORDS);

  logic        cfg_pwr, pwr_ok, progfail;
  logic [31:0] wdata_r, glock_r, exp_r;
  logic [NBANK*32-1:0] err_map, dist_map;
  logic [31:0] shadow [N_WORDS];

  // bus decode
  logic wr_hit, cfg_wr, ctrl_wr, wd_wr, gl_wr, sh_hit, sh_wr;
  logic [11:0] sh_off;
  logic [9:0]  sh_word;
  assign wr_hit  = bus_en && bus_we;
  assign cfg_wr  = wr_hit && bus_addr == A_CFG;
  assign ctrl_wr = wr_hit && bus_addr == A_CTRL;
  assign wd_wr   = wr_hit && bus_addr == A_WDATA;
  assign gl_wr   = wr_hit && bus_addr == A_GLOCK;
  assign sh_off  = bus_addr - A_SHADOW;
  assign sh_word = sh_off[11:2];
  assign sh_hit  = (bus_addr >= A_SHADOW) && (sh_word < 10'(N_WORDS));
  assign sh_wr   = wr_hit && sh_hit;

  // command field decode
  logic            cmd_valid, cmd_go, cmd_dead, cmd_refuse, busy, burn, fin, cur_refused;
  logic [IDXW-1:0] cmd_idx, cur_idx, rd_idx, burn_addr;
  op_t             cmd_op, cur_op;
  assign cmd_valid  = bus_wdata[7:0] < N_IDX;
  assign cmd_idx    = bus_wdata[IDXW-1:0];
  assign cmd_op     = (bus_wdata[8] && bus_wdata[9]) ? OP_LOCK :
                      bus_wdata[8] ? OP_PROG : OP_READ;
  assign cmd_refuse = (cmd_op != OP_READ) && glock_r[PLOCK_BIT];
  assign cmd_go     = ctrl_wr && !busy && pwr_ok && cmd_valid;
  assign cmd_dead   = ctrl_wr && !busy && !pwr_ok && cmd_valid;

  otp_fuse_pwr #(.PWR_DLY(PWR_DLY)) u_pwr (
    .clk(clk), .rst_n(rst_n), .pwr_req(cfg_pwr), .pwr_ok(pwr_ok));

  otp_fuse_fsm #(.IDXW(IDXW), .RD_CYC(RD_CYC), .PRG_CYC(PRG_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .cmd_refuse(cmd_refuse), .busy(busy), .burn(burn), .fin(fin), .cur_op(cur_op),
    .cur_idx(cur_idx), .cur_refused(cur_refused));

  // lock-area encoding for the incoming and the running command
  logic [LAW-1:0] la_bus, la_cur;
  logic [31:0]    ld_bus, ld_cur, lk_bus_word, lk_cur_word, rd_word, cmp_word;
  logic [LOCK_WORDS*32-1:0] lock_flat;
  assign la_bus      = LAW'(lk_word(32'(cmd_idx), UPPER_BASE));
  assign la_cur      = LAW'(lk_word(32'(cur_idx), UPPER_BASE));
  assign ld_bus      = lk_data(32'(cmd_idx), UPPER_BASE);
  assign ld_cur      = lk_data(32'(cur_idx), UPPER_BASE);
  assign lk_bus_word = lock_flat[32*int'(la_bus) +: 32];
  assign lk_cur_word = lock_flat[32*int'(la_cur) +: 32];

  assign rd_idx    = busy ? cur_idx : cmd_idx;
  assign burn_addr = (cur_op == OP_LOCK) ? IDXW'(la_cur) : cur_idx;
  assign cmp_word  = (cur_op == OP_LOCK) ? lk_cur_word : rd_word;

  otp_fuse_model #(.N_WORDS(N_WORDS), .LOCK_WORDS(LOCK_WORDS), .IDXW(IDXW),
                   .BAD_WORD(BAD_WORD), .BAD_MASK(BAD_MASK)) u_model (
    .clk(clk), .rst_n(rst_n), .burn_en(burn), .burn_lock(cur_op == OP_LOCK),
    .burn_addr(burn_addr), .burn_data((cur_op == OP_LOCK) ? ld_cur : wdata_r),
    .rd_idx(rd_idx), .rd_word(rd_word), .lock_flat(lock_flat));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_pwr  <= 1'b0;
      wdata_r  <= '0;
      glock_r  <= '0;
      exp_r    <= '0;
      progfail <= 1'b0;
      err_map  <= '0;
      dist_map <= '0;
      for (int i = 0; i < N_WORDS; i++) shadow[i] <= '0;
    end else begin
      if (cfg_wr) cfg_pwr <= bus_wdata[0];
      if (wd_wr)  wdata_r <= bus_wdata;
      if (gl_wr)  glock_r <= glock_r | bus_wdata;
      if (sh_wr)  shadow[sh_word] <= bus_wdata;
      if (cmd_dead) err_map[cmd_idx] <= 1'b1;
      if (cmd_go) begin
        progfail <= 1'b0;
        exp_r    <= (cmd_op == OP_LOCK) ? (lk_bus_word | ld_bus) : (rd_word | wdata_r);
      end
      if (fin) begin
        if (cur_refused) begin
          progfail         <= 1'b1;
          err_map[cur_idx] <= 1'b1;
        end else begin
          case (cur_op)
            OP_READ: begin
              shadow[cur_idx]   <= rd_word;
              err_map[cur_idx]  <= 1'b0;
              dist_map[cur_idx] <= 1'b0;
            end
            OP_PROG: begin
              err_map[cur_idx]  <= 1'b0;
              dist_map[cur_idx] <= (cmp_word != exp_r);
            end
            default: err_map[cur_idx] <= (cmp_word != exp_r);
          endcase
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG:    bus_rdata = {31'b0, cfg_pwr};
      A_WDATA:  bus_rdata = wdata_r;
      A_STATUS: bus_rdata = 32'(pwr_ok) << PWR_BIT | 32'(progfail) << FAIL_BIT
                          | 32'(busy) << BUSY_BIT;
      A_GLOCK:  bus_rdata = glock_r;
      default:  bus_rdata = '0;
    endcase
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == A_DIST + 12'(4*b)) bus_rdata = dist_map[b*32 +: 32];
      if (bus_addr == A_ERR  + 12'(4*b)) bus_rdata = err_map[b*32 +: 32];
    end
    for (int k = 0; k < LOCK_WORDS; k++)
      if (bus_addr == A_LKWIN + 12'(4*k)) bus_rdata = lock_flat[k*32 +: 32];
    if (sh_hit) bus_rdata = shadow[sh_word];
  end

  p_read_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && cur_op == OP_READ && !cur_refused) |=> (shadow[$past(cur_idx)] == $past(rd_word)));
  p_fail_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(progfail) |-> $past(glock_r[PLOCK_BIT]));
  p_dead_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dead |=> err_map[$past(cmd_idx)]);
  p_go_powered_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pwr_ok));

endmodule

// File: tb/otp_fuse_seq_bench.sv
`timescale 1ns/1ps
module otp_fuse_seq_bench;
  localparam int NW = 96, UB = 32, PD = 4, BADW = 70;
  localparam logic [31:0] BADM = 32'h0000_0100;

  logic clk = 0, rst_n = 0, bus_en = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [31:0] bm [NW];
  logic [31:0] lkm [8];

  always #2 clk = ~clk;

  otp_fuse_seq #(.N_WORDS(NW), .UPPER_BASE(UB), .PWR_DLY(PD), .RD_CYC(3), .PRG_CYC(6),
                 .BAD_WORD(BADW), .BAD_MASK(BADM)) u_otp_fuse_seq (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // program vectors: {index, value}
  localparam logic [39:0] VEC [8] = '{
    {8'd0,  32'h0000_0001}, {8'd0,  32'h0000_0010}, {8'd31, 32'hA5A5_0000},
    {8'd32, 32'h0000_5A5A}, {8'd95, 32'hFFFF_FFFF}, {8'd64, 32'h8000_0001},
    {8'd31, 32'h0000_00FF}, {8'd33, 32'h0F0F_0F0F}};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic brd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 200; n++) begin
      brd(12'h00C, s);
      if (!s[3]) break;
      @(negedge clk);
    end
  endtask

  task automatic do_cmd(input logic [31:0] c);
    bwr(12'h004, c);
    wait_idle();
  endtask

  function automatic logic [11:0] shaddr(input int i);
    return 12'h200 + 12'(i * 4);
  endfunction

  initial begin
    logic [31:0] r;
    for (int i = 0; i < NW; i++) bm[i] = 0;
    for (int k = 0; k < 8; k++) lkm[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12 reset state
    brd(12'h00C, r); check("R12 status", r, 0);
    brd(12'h000, r); check("R12 cfg", r, 0);
    brd(shaddr(5), r); check("R12 shadow", r, 0);
    brd(12'h038, r); check("R12 error bank1", r, 0);
    brd(12'h0C4, r); check("R12 lock area", r, 0);

    // R6 powered down: command ignored, error flag of word 40 (bank1 bit8, R7)
    bwr(12'h004, 32'h0000_0028);
    brd(12'h00C, r); check("R6 no busy when unpowered", r[3], 0);
    brd(12'h038, r); check("R6 R7 error bank1 bit8", r, 32'h0000_0100);

    // R1 power-good timing
    bwr(12'h000, 32'h1);
    brd(12'h00C, r); check("R1 pwr low right after request", r[5], 0);
    repeat (PD - 1) @(negedge clk);
    brd(12'h00C, r); check("R1 pwr low at PD-1", r[5], 0);
    @(negedge clk);
    brd(12'h00C, r); check("R1 pwr high at PD", r[5], 1);

    // R7 read clears error flag of word 40
    do_cmd(32'h0000_0028);
    brd(12'h038, r); check("R7 error cleared by read", r, 0);

    // R2 R3 vector table
    foreach (VEC[v]) begin
      int idx = int'(VEC[v][39:32]);
      bwr(12'h008, VEC[v][31:0]);
      do_cmd(32'h100 | idx);
      bm[idx] = bm[idx] | VEC[v][31:0];
      do_cmd(32'(idx));
      brd(shaddr(idx), r); check("R2 R3 shadow after program+read", r, bm[idx]);
    end

    // R4 busy and dropped command
    bwr(shaddr(1), 32'hDEAD_BEEF);
    bwr(12'h004, 32'h0000_0002);
    brd(12'h00C, r); check("R4 busy during command", r[3], 1);
    bwr(12'h004, 32'h0000_0001);
    wait_idle();
    brd(shaddr(1), r); check("R4 command while busy ignored", r, 32'hDEAD_BEEF);

    // R11 shadow write does not touch fuses
    bwr(shaddr(0), 32'h1234_5678);
    brd(shaddr(0), r); check("R11 shadow takes bus write", r, 32'h1234_5678);
    do_cmd(32'h0);
    brd(shaddr(0), r); check("R11 read restores fuse value", r, bm[0]);

    // R13 out-of-range index
    bwr(12'h004, 32'h100 | 100);
    brd(12'h00C, r); check("R13 out-of-range not busy", r[3], 0);

    // R8 defective word: bit 8 cannot burn
    bwr(12'h008, 32'h0000_0101);
    do_cmd(32'h100 | BADW);
    brd(12'h024, r); check("R8 disturbed bank2 bit6", r, 32'h0000_0040);
    brd(12'h03C, r); check("R8 error clear on mismatch", r, 0);
    do_cmd(32'(BADW));
    brd(shaddr(BADW), r); check("R8 stored value lacks stuck bit", r, 32'h0000_0001);
    brd(12'h024, r); check("R7 read clears disturbed", r, 0);

    // R9 lower-region locks, R10 upper-region locks
    foreach (VEC[v]) begin end
    for (int t = 0; t < 5; t++) begin
      int w = (t == 0) ? 5 : (t == 1) ? 13 : (t == 2) ? 70 : (t == 3) ? 71 : 86;
      int la; logic [31:0] d;
      if (w < UB) begin la = w / 8; d = 32'd3 << ((w % 8) * 2); end
      else        begin la = w / 16 + 2; d = 32'd1 << (w % 16); end
      do_cmd(32'h300 | w);
      lkm[la] = lkm[la] | d;
      for (int k = 0; k < 8; k++) begin
        brd(12'h0C0 + 12'(4 * k), r);
        check((w < UB) ? "R9 lock area" : "R10 lock area", r, lkm[k]);
      end
    end

    // R5 global program lock
    bwr(12'h010, 32'h0000_0010);
    bwr(shaddr(2), 32'h0000_FFFF);
    bwr(12'h008, 32'h0000_000F);
    do_cmd(32'h102);
    brd(12'h00C, r); check("R5 program fail set", r[4], 1);
    brd(12'h034, r); check("R5 error flag word2", r[2], 1);
    do_cmd(32'h2);
    brd(12'h00C, r); check("R5 program fail cleared", r[4], 0);
    brd(shaddr(2), r); check("R5 fuse not burnt", r, 0);
    do_cmd(32'h300 | 13);
    brd(12'h0C4, r); check("R5 lock refused", r, lkm[1]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule